// File: doc/BRIEF.md
# Byte-Wide Strobed Bus Master

This block carries register reads and writes from a simple request port onto a narrow strobed bus that talks to a slower peripheral. Each transaction moves a 16-bit value to or from an 8-bit register address. The bus has one byte-wide data path, which the master drives or releases, and five control lines. Those lines are a chip-select (active low), a direction line, a strobe, an address-latch line and a ready line that the peripheral returns.

A transaction is a sequence of byte phases. The address phase comes first and the value bytes follow, most significant byte first. Every phase starts by pulling the bus back to a cleared state and ends by raising the strobe. After the last byte the master raises chip-select and polls ready. On a read, a high ready means the whole two-byte read is repeated. On a write, chip-select is pulsed low and back high until ready drops. A retry limit ends a transaction with an error if ready stays high. Every control-line change is held for a fixed number of system clocks, so the peripheral always sees settled levels.

Top module: `strobed_bus_master`

## Requirements
- R1: After reset and whenever not busy, the bus rests with chip-select, strobe and address-latch high, data driven (bus_oe=1) to all ones, and busy, done and err low.
- R2: bus_dir is 0 for the whole of a read and 1 for the whole of a write, changes only when busy starts or ends, and data is driven throughout a write.
- R3: Every byte phase begins with the strobe falling while chip-select and address-latch are low and any driven data is all zeros; the strobe then rises to start the phase.
- R4: The first strobe of a transaction carries the address on bus_dout with address-latch high; the value bytes of a write follow with address-latch low, bits 15:8 before bits 7:0.
- R5: On a read the data lines are released (bus_oe=0) for every value-byte strobe, and each byte is taken from bus_din with bit i on line i, the high byte first.
- R6: On a read, ready is sampled after chip-select rises; while it is high, both value bytes are read again and only the final attempt's value reaches rd_data.
- R7: On a write, ready is sampled after chip-select rises; while it is high, chip-select is pulsed low then high again, and the write completes on the first low sample.
- R8: At completion the bus returns to the rest state of R1, with data driven high again after a read.
- R9: Within a transaction, every change of the control lines or of the driven data stays stable for at least STEP_CLKS clocks.
- R10: A request is taken only while idle; busy stays high until the done cycle, and a request raised while busy has no effect.
- R11: If ready is still high after MAX_RETRY repeats, the transaction ends with err=1 in the done cycle; err is never high outside done.
- R12: done is a one-cycle pulse, and rd_data holds the read value from that cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken only while idle |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_addr | input | ADDR_W | Register address |
| req_wdata | input | VAL_W | Value to write |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Retry limit reached, valid with done |
| rd_data | output | VAL_W | Value of the last completed read |
| bus_dout | output | DATA_W | Data driven onto the bus |
| bus_oe | output | 1 | Data output enable for the bus pad |
| bus_din | input | DATA_W | Data seen on the bus |
| bus_csn | output | 1 | Chip-select, active low |
| bus_dir | output | 1 | Direction: 0 read, 1 write |
| bus_stb | output | 1 | Phase strobe |
| bus_ale | output | 1 | High during the address phase |
| bus_rdy | input | 1 | Peripheral ready/busy, asynchronous |

## Verification
The bench builds the block with STEP_CLKS=3, SYNC_STAGES=2 and MAX_RETRY=3. The step is the shortest one the synchronizer allows, and the retry limit is small, so every retry count fits in a short run: zero to three repeats, and one more than the limit. The bench runs each count for both reads and writes at addresses and values that set and clear every bit position. A peripheral model returns a different value on each read attempt, so the bench can tell whether a stale attempt reaches rd_data. Two requests raised mid-transaction test that busy requests are ignored.

// File: rtl/sbm_pkg.sv
package sbm_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_DIR,
      ST_CLR,
      ST_SETUP,
      ST_STB,
      ST_POLL,
      ST_CSNLO
   } sbm_state_e;

   typedef struct packed {
      logic csn;
      logic stb;
      logic ale;
      logic dir;
      logic oe;
   } sbm_lines_t;

   localparam sbm_lines_t SBM_LINES_REST = '{csn: 1'b1, stb: 1'b1, ale: 1'b1, dir: 1'b1, oe: 1'b1};

endpackage

// File: rtl/sbm_sync.sv
module sbm_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] chain_q;

   generate
      if (STAGES < 2) begin : g_bad
         $error("sbm_sync needs at least two stages");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-2:0], d};
   end

   assign q = chain_q[STAGES-1];
endmodule

// File: rtl/sbm_pacer.sv
module sbm_pacer #(
   parameter int STEP_CLKS = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   output logic tick
);
   localparam int CW = $clog2(STEP_CLKS + 1);
   localparam logic [CW-1:0] RELOAD = CW'(STEP_CLKS - 1);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt_q <= '0;
      else if (load)           cnt_q <= RELOAD;
      else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
   end

   assign tick = (cnt_q == '0);
endmodule

// File: rtl/sbm_retry.sv
module sbm_retry #(
   parameter int MAX_RETRY = 255
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic inc,
   output logic at_limit
);
   localparam int RW = $clog2(MAX_RETRY + 1);
   localparam logic [RW-1:0] LIMIT = RW'(MAX_RETRY);

   logic [RW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   cnt_q <= '0;
      else if (clr)                 cnt_q <= '0;
      else if (inc && !at_limit)    cnt_q <= cnt_q + 1'b1;
   end

   assign at_limit = (cnt_q == LIMIT);
endmodule

// File: rtl/strobed_bus_master.sv
module strobed_bus_master
   import sbm_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int ADDR_W      = 8,
   parameter int VAL_W       = 16,
   parameter int STEP_CLKS   = 4,
   parameter int SYNC_STAGES = 2,
   parameter int MAX_RETRY   = 255
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [VAL_W-1:0]  req_wdata,
   output logic              busy,
   output logic              done,
   output logic              err,
   output logic [VAL_W-1:0]  rd_data,
   output logic [DATA_W-1:0] bus_dout,
   output logic              bus_oe,
   input  logic [DATA_W-1:0] bus_din,
   output logic              bus_csn,
   output logic              bus_dir,
   output logic              bus_stb,
   output logic              bus_ale,
   input  logic              bus_rdy
);
   localparam int NBYTES = VAL_W / DATA_W;
   localparam int IDX_W  = (NBYTES > 1) ? $clog2(NBYTES) : 1;
   localparam logic [IDX_W-1:0] IDX_TOP = IDX_W'(NBYTES - 1);

   generate
      if (VAL_W % DATA_W != 0 || NBYTES < 1) begin : g_bad_val
         $error("VAL_W must be a whole number of DATA_W bytes");
      end
      if (ADDR_W != DATA_W) begin : g_bad_addr
         $error("the address is sent as one byte: ADDR_W must equal DATA_W");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (STEP_CLKS <= SYNC_STAGES) begin : g_bad_step
         $error("STEP_CLKS must exceed SYNC_STAGES so ready settles in one step");
      end
      if (MAX_RETRY < 1) begin : g_bad_retry
         $error("MAX_RETRY must be at least 1");
      end
   endgenerate

   // state and request registers
   sbm_state_e        state_q, state_d;
   logic              is_addr_q, is_addr_d;
   logic [IDX_W-1:0]  idx_q, idx_d;
   logic              wr_q;
   logic [ADDR_W-1:0] addr_q;
   logic [VAL_W-1:0]  wdata_q;
   logic [VAL_W-1:0]  rdbuf_q;
   logic [VAL_W-1:0]  rd_data_q;
   sbm_lines_t        lines_q, lines_d;
   logic [DATA_W-1:0] dout_q, dout_d;
   logic              done_q, err_q;

   // sequencing strobes
   logic tick, load, rdy_s, at_limit;
   logic accept, retry_inc, capture, finish, fin_err;
   logic wr_n, drive;
   logic [DATA_W-1:0] byte_v;

   sbm_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (bus_rdy),
      .q     (rdy_s)
   );

   sbm_pacer #(.STEP_CLKS(STEP_CLKS)) u_pacer (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (load),
      .tick  (tick)
   );

   sbm_retry #(.MAX_RETRY(MAX_RETRY)) u_retry (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (accept),
      .inc      (retry_inc),
      .at_limit (at_limit)
   );

   // next-state sequencing
   always_comb begin
      state_d   = state_q;
      is_addr_d = is_addr_q;
      idx_d     = idx_q;
      load      = 1'b0;
      accept    = 1'b0;
      retry_inc = 1'b0;
      capture   = 1'b0;
      finish    = 1'b0;
      fin_err   = 1'b0;
      if (state_q == ST_IDLE) begin
         if (req_valid) begin
            accept  = 1'b1;
            load    = 1'b1;
            state_d = ST_DIR;
         end
      end else if (tick) begin
         load = 1'b1;
         case (state_q)
            ST_DIR: begin
               state_d   = ST_CLR;
               is_addr_d = 1'b1;
               idx_d     = IDX_TOP;
            end
            ST_CLR: begin
               state_d = (!wr_q && !is_addr_q) ? ST_STB : ST_SETUP;
            end
            ST_SETUP: begin
               state_d = ST_STB;
            end
            ST_STB: begin
               capture = !wr_q && !is_addr_q;
               if (is_addr_q) begin
                  is_addr_d = 1'b0;
                  idx_d     = IDX_TOP;
                  state_d   = ST_CLR;
               end else if (idx_q != '0) begin
                  idx_d   = idx_q - 1'b1;
                  state_d = ST_CLR;
               end else begin
                  state_d = ST_POLL;
               end
            end
            ST_POLL: begin
               if (!rdy_s) begin
                  finish  = 1'b1;
                  state_d = ST_IDLE;
               end else if (at_limit) begin
                  finish  = 1'b1;
                  fin_err = 1'b1;
                  state_d = ST_IDLE;
               end else begin
                  retry_inc = 1'b1;
                  if (wr_q) begin
                     state_d = ST_CSNLO;
                  end else begin
                     idx_d   = IDX_TOP;
                     state_d = ST_CLR;
                  end
               end
            end
            ST_CSNLO: begin
               state_d = ST_POLL;
            end
            default: begin
               state_d = ST_IDLE;
            end
         endcase
      end
   end

   // bus levels for the state being entered
   always_comb begin
      wr_n    = accept ? req_write : wr_q;
      drive   = wr_n || is_addr_d;
      byte_v  = is_addr_d ? DATA_W'(addr_q) : wdata_q[int'(idx_d)*DATA_W +: DATA_W];
      lines_d = SBM_LINES_REST;
      dout_d  = '1;
      case (state_d)
         ST_DIR: begin
            lines_d.dir = wr_n;
         end
         ST_CLR: begin
            lines_d = '{csn: 1'b0, stb: 1'b0, ale: 1'b0, dir: wr_n, oe: drive};
            dout_d  = '0;
         end
         ST_SETUP: begin
            lines_d = '{csn: 1'b0, stb: 1'b0, ale: is_addr_d, dir: wr_n, oe: 1'b1};
            dout_d  = byte_v;
         end
         ST_STB: begin
            lines_d = '{csn: 1'b0, stb: 1'b1, ale: is_addr_d, dir: wr_n, oe: drive};
            dout_d  = drive ? byte_v : '0;
         end
         ST_POLL: begin
            lines_d = '{csn: 1'b1, stb: 1'b1, ale: 1'b0, dir: wr_n, oe: wr_n};
            dout_d  = wr_n ? byte_v : '0;
         end
         ST_CSNLO: begin
            lines_d = '{csn: 1'b0, stb: 1'b1, ale: 1'b0, dir: wr_n, oe: wr_n};
            dout_d  = wr_n ? byte_v : '0;
         end
         default: begin
            lines_d = SBM_LINES_REST;
            dout_d  = '1;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         is_addr_q <= 1'b0;
         idx_q     <= '0;
         wr_q      <= 1'b0;
         addr_q    <= '0;
         wdata_q   <= '0;
         rdbuf_q   <= '0;
         rd_data_q <= '0;
         lines_q   <= SBM_LINES_REST;
         dout_q    <= '1;
         done_q    <= 1'b0;
         err_q     <= 1'b0;
      end else begin
         state_q   <= state_d;
         is_addr_q <= is_addr_d;
         idx_q     <= idx_d;
         lines_q   <= lines_d;
         dout_q    <= dout_d;
         done_q    <= finish;
         err_q     <= fin_err;
         if (accept) begin
            wr_q    <= req_write;
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
         end
         if (capture) rdbuf_q[int'(idx_q)*DATA_W +: DATA_W] <= bus_din;
         if (finish && !wr_q) rd_data_q <= rdbuf_q;
      end
   end

   assign busy     = (state_q != ST_IDLE);
   assign done     = done_q;
   assign err      = err_q;
   assign rd_data  = rd_data_q;
   assign bus_dout = dout_q;
   assign bus_oe   = lines_q.oe;
   assign bus_csn  = lines_q.csn;
   assign bus_dir  = lines_q.dir;
   assign bus_stb  = lines_q.stb;
   assign bus_ale  = lines_q.ale;
endmodule

// File: rtl/sbm_checker.sv
module sbm_checker #(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              busy,
   input logic              done,
   input logic              err,
   input logic [DATA_W-1:0] bus_dout,
   input logic              bus_oe,
   input logic              bus_csn,
   input logic              bus_dir,
   input logic              bus_stb,
   input logic              bus_ale
);
   AST_REST_LINES: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> bus_csn && bus_stb && bus_ale && bus_oe && (bus_dout == '1)); // R1

   AST_DIR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(bus_dir) |-> (busy != $past(busy))); // R2

   AST_WRITE_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
      busy && bus_dir |-> bus_oe); // R2

   AST_PHASE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(bus_stb) |-> !bus_csn && !bus_ale && (!bus_oe || bus_dout == '0)); // R3

   AST_READ_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
      busy && !bus_dir && bus_stb && !bus_csn && !bus_ale |-> !bus_oe); // R5

   AST_STEP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      busy && !$stable({bus_csn, bus_stb, bus_ale, bus_dir, bus_oe, bus_dout})
      |=> $stable({bus_csn, bus_stb, bus_ale, bus_dir, bus_oe, bus_dout})); // R9

   AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy && $past(busy)); // R10

   AST_ERR_IN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> done); // R11

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R12
endmodule

bind strobed_bus_master sbm_checker #(.DATA_W(DATA_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .busy     (busy),
   .done     (done),
   .err      (err),
   .bus_dout (bus_dout),
   .bus_oe   (bus_oe),
   .bus_csn  (bus_csn),
   .bus_dir  (bus_dir),
   .bus_stb  (bus_stb),
   .bus_ale  (bus_ale)
);

// File: tb/strobed_bus_master_tb.sv
module strobed_bus_master_tb;
   localparam int DW = 8, AW = 8, VW = 16, STEP = 3, SYNC = 2, MAXR = 3;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0, req_write = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [VW-1:0] req_wdata = '0;
   logic          busy, done, err;
   logic [VW-1:0] rd_data;
   logic [DW-1:0] bus_dout, bus_din = '0;
   logic          bus_oe, bus_csn, bus_dir, bus_stb, bus_ale;
   logic          bus_rdy = 1'b0;

   strobed_bus_master #(
      .DATA_W(DW), .ADDR_W(AW), .VAL_W(VW),
      .STEP_CLKS(STEP), .SYNC_STAGES(SYNC), .MAX_RETRY(MAXR)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy), .done(done),
      .err(err), .rd_data(rd_data), .bus_dout(bus_dout), .bus_oe(bus_oe),
      .bus_din(bus_din), .bus_csn(bus_csn), .bus_dir(bus_dir), .bus_stb(bus_stb),
      .bus_ale(bus_ale), .bus_rdy(bus_rdy)
   );

   int n_chk = 0, n_fail = 0;

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // peripheral model state
   logic [15:0] mem [0:255];
   logic        prev_stb = 1'b1, prev_csn = 1'b1;
   logic [12:0] ctl_prev = '1;
   int          gap = 100;
   int          k_busy = 0, polls = 0, strobes = 0, addr_strobes = 0, first_ale = 0;
   int          wr_cnt = 0, rd_idx = 0;
   int          dir_bad = 0, clr_bad = 0, oe_bad = 0, pace_bad = 0;
   logic        expect_dir = 1'b1;
   logic [7:0]  lat_addr = '0;
   logic [7:0]  wb0 = '0, wb1 = '0;

   always @(negedge clk) begin
      logic [12:0] cur;
      logic [15:0] val;
      if (rst_n) begin
         cur = {bus_csn, bus_stb, bus_ale, bus_dir, bus_oe, bus_dout};
         if (cur !== ctl_prev) begin
            if (busy && gap < STEP) pace_bad++;
            gap = 1;
         end else begin
            gap++;
         end
         ctl_prev = cur;
         if (!prev_stb && bus_stb) begin
            strobes++;
            if (bus_dir !== expect_dir) dir_bad++;
            if (bus_ale) begin
               addr_strobes++;
               if (strobes == 1 && bus_oe) first_ale = 1;
               lat_addr = bus_dout;
               rd_idx = 0;
            end else if (bus_dir) begin
               if (wr_cnt == 0) wb0 = bus_dout;
               if (wr_cnt == 1) wb1 = bus_dout;
               wr_cnt++;
            end else begin
               if (bus_oe) oe_bad++;
               val = mem[lat_addr] ^ 16'(16'h0101 * polls);
               bus_din = (rd_idx == 0) ? val[15:8] : val[7:0];
               rd_idx++;
            end
         end
         if (prev_stb && !bus_stb) begin
            if (bus_csn || bus_ale || (bus_oe && bus_dout != '0)) clr_bad++;
         end
         if (!prev_csn && bus_csn && busy) begin
            polls++;
            if (bus_dir !== expect_dir) dir_bad++;
            bus_rdy = (polls <= k_busy);
            rd_idx = 0;
         end
         prev_stb = bus_stb;
         prev_csn = bus_csn;
      end
   end

   task automatic run_txn(input logic wr, input logic [7:0] a, input logic [15:0] wd,
                          input int k, input logic intrude);
      int cyc;
      int exp_polls;
      logic [15:0] exp_rd;
      k_busy = k; polls = 0; strobes = 0; addr_strobes = 0; first_ale = 0;
      wr_cnt = 0; rd_idx = 0; dir_bad = 0; clr_bad = 0; oe_bad = 0; pace_bad = 0;
      expect_dir = wr; bus_rdy = 1'b0;
      exp_polls = ((k < MAXR) ? k : MAXR) + 1;
      exp_rd = mem[a] ^ 16'(16'h0101 * (exp_polls - 1));
      @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = wd;
      @(negedge clk);
      req_valid = 1'b0;
      check("R10 busy after request", 32'(busy), 32'd1);
      if (intrude) begin
         repeat (5) @(negedge clk);
         req_valid = 1'b1; req_write = !wr; req_addr = ~a; req_wdata = ~wd;
         @(negedge clk);
         req_valid = 1'b0;
      end
      cyc = 0;
      while (!done && cyc < 2000) begin
         @(negedge clk);
         cyc++;
      end
      check("R10 transaction completes", 32'(done), 32'd1);
      check("R11 err flag", 32'(err), 32'(k > MAXR));
      check("R2 direction held", 32'(dir_bad), 32'd0);
      check("R3 phase clear", 32'(clr_bad), 32'd0);
      check("R9 step hold", 32'(pace_bad), 32'd0);
      check("R4 one address strobe first", 32'({addr_strobes[7:0], first_ale[7:0]}), 32'h0101);
      check("R4 address byte", 32'(lat_addr), 32'(a));
      check("R8 rest lines at done", 32'({busy, bus_csn, bus_stb, bus_ale, bus_oe, bus_dout}),
            32'({1'b0, 4'hF, 8'hFF}));
      if (wr) begin
         check("R7 poll count", 32'(polls), 32'(exp_polls));
         check("R4 write bytes msb first", 32'({wr_cnt[7:0], wb0, wb1}), 32'({8'd2, wd}));
      end else begin
         check("R6 read attempts", 32'(polls), 32'(exp_polls));
         check("R5 released on read bytes", 32'(oe_bad), 32'd0);
         check("R6 final attempt value", 32'(rd_data), 32'(exp_rd));
      end
      @(negedge clk);
      check("R12 done single cycle", 32'(done), 32'd0);
      if (!wr) check("R12 rd_data held", 32'(rd_data), 32'(exp_rd));
      if (intrude) begin
         repeat (12) @(negedge clk);
         check("R10 busy request ignored", 32'({busy, addr_strobes[7:0]}), 32'({1'b0, 8'd1}));
      end
      repeat (4) @(negedge clk);
   endtask

   initial begin
      for (int i = 0; i < 256; i++) mem[i] = 16'((i * 16'h0123) ^ 16'hC3A5 ^ (i << 8));
      repeat (3) @(negedge clk);
      check("R1 rest after reset", 32'({busy, done, err, bus_csn, bus_stb, bus_ale, bus_oe, bus_dout}),
            32'({3'b000, 4'hF, 8'hFF}));
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      check("R1 rest idle", 32'({busy, done, err, bus_csn, bus_stb, bus_ale, bus_oe, bus_dout}),
            32'({3'b000, 4'hF, 8'hFF}));
      for (int wr = 0; wr < 2; wr++) begin
         for (int k = 0; k <= MAXR + 1; k++) begin
            for (int ai = 0; ai < 4; ai++) begin
               logic [7:0] a;
               a = (ai == 0) ? 8'h00 : (ai == 1) ? 8'h5A : (ai == 2) ? 8'hA5 : 8'hFF;
               run_txn(wr[0], a, 16'({a, ~a} ^ (k * 16'h1111)), k, 1'b0);
            end
         end
      end
      run_txn(1'b1, 8'h3C, 16'h8001, 2, 1'b1);
      run_txn(1'b0, 8'hC3, 16'h0000, 1, 1'b1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL R10 watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule